// File: doc/BRIEF.md
# Landing Gear Door Warning Annunciator

This block turns the position switches of the five landing gear doors into lamp drive for the cockpit. Each switch reads 1 while its door is open. For every door there is one warning lamp, and a master warning lamp comes on whenever any door is open. All lamp outputs are active-low: driving 0 lights a lamp and driving 1 leaves it dark.

There are two redundant decoding channels, primary and secondary. Each channel takes its own copy of the five switch inputs. A select input, set by the pilot, chooses which channel drives the lamps. A panel enable switch can turn off the five per-door lamps. The master lamp does not depend on this enable. Every lamp output comes from a register, so its value reflects the inputs sampled at the previous rising clock edge. A synchronous active-high reset turns every lamp dark.

Top module: `gear_door_annunciator`

## Requirements
- R1: If `rst` is 1 at a rising clock edge, then after that edge every bit of `door_lamp_n` is 1 and `master_lamp_n` is 1, whatever the door inputs are.
- R2: If every door bit of the selected channel is 0, then after the next edge every lamp output is 1 (all lamps dark).
- R3: If one or more door bits of the selected channel are 1, then after the next edge `master_lamp_n` is 0.
- R4: While `panel_en` is 1, bit i of `door_lamp_n` after an edge is 0 exactly when bit i of the selected channel's door vector was 1 at that edge. Bit i of the door vector always maps to bit i of the lamp vector.
- R5: While `panel_en` is 0, every bit of `door_lamp_n` after the edge is 1, whichever doors are open.
- R6: `master_lamp_n` follows the selected channel whatever the value of `panel_en`.
- R7: When `chan_sel` is 0, the lamps are computed from `doors_pri`. When it is 1, they are computed from `doors_sec`. The channel that is not selected has no effect on any output.
- R8: The outputs change only at a rising clock edge. An input change made between edges does not appear on the outputs until the following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the outputs update on the rising edge |
| rst | input | 1 | Synchronous reset, active high; all lamps go dark |
| doors_pri | input | 5 | Primary channel door switches, 1 = door open |
| doors_sec | input | 5 | Secondary channel door switches, 1 = door open |
| chan_sel | input | 1 | Channel select: 0 = primary, 1 = secondary |
| panel_en | input | 1 | Per-door lamp enable, 1 = lamps allowed |
| door_lamp_n | output | 5 | Per-door warning lamps, active low |
| master_lamp_n | output | 1 | Master door warning lamp, active low |

## Verification
The bench drives the two channels with different door patterns, so that a design reading the wrong channel, or mixing the two, lights lamps that do not match the selected inputs. It clears the panel enable while doors are open. A design that gates the master lamp with the enable would then leave the master dark, and one that ignores the enable would light door lamps. It also uses single doors at both ends of the vector and an asymmetric pattern of two doors, which expose swapped or reversed bit order, and it asserts reset while every door is open. Last, it changes an input between edges and checks that the output keeps its old value until the next rising edge.

// File: rtl/gda_pkg.sv
package gda_pkg;
  localparam int unsigned DEFAULT_DOORS = 5;
  localparam int unsigned CHANNELS      = 2;

  typedef enum logic {
    CH_PRIMARY   = 1'b0,
    CH_SECONDARY = 1'b1
  } chan_e;
endpackage

// File: rtl/gda_channel.sv
module gda_channel #(
  parameter int unsigned N_DOORS = gda_pkg::DEFAULT_DOORS
) (
  input  logic [N_DOORS-1:0] door_open,
  output logic [N_DOORS-1:0] warn,
  output logic               any_open
);
  function automatic logic f_any(input logic [N_DOORS-1:0] v);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < N_DOORS; i++) acc = acc | v[i];
    return acc;
  endfunction

  for (genvar g = 0; g < N_DOORS; g++) begin : g_door
    assign warn[g] = door_open[g];
  end

  assign any_open = f_any(door_open);
endmodule

// File: rtl/gda_select.sv
module gda_select #(
  parameter int unsigned N_DOORS = gda_pkg::DEFAULT_DOORS
) (
  input  gda_pkg::chan_e     chan_sel,
  input  logic [N_DOORS-1:0] pri_warn,
  input  logic               pri_any,
  input  logic [N_DOORS-1:0] sec_warn,
  input  logic               sec_any,
  output logic [N_DOORS-1:0] sel_warn,
  output logic               sel_any
);
  always_comb begin
    if (chan_sel == gda_pkg::CH_SECONDARY) begin
      sel_warn = sec_warn;
      sel_any  = sec_any;
    end else begin
      sel_warn = pri_warn;
      sel_any  = pri_any;
    end
  end
endmodule

// File: rtl/gda_lamp_stage.sv
module gda_lamp_stage #(
  parameter int unsigned N_DOORS = gda_pkg::DEFAULT_DOORS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               panel_en,
  input  logic [N_DOORS-1:0] sel_warn,
  input  logic               sel_any,
  output logic [N_DOORS-1:0] door_lamp_n,
  output logic               master_lamp_n
);
  localparam logic [N_DOORS-1:0] ALL_DARK = '1;

  function automatic logic [N_DOORS-1:0] f_door_drive(
    input logic [N_DOORS-1:0] warn, input logic en);
    return en ? ~warn : ALL_DARK;
  endfunction

  logic [N_DOORS-1:0] door_next;
  logic               master_next;

  assign door_next   = f_door_drive(sel_warn, panel_en);
  assign master_next = ~sel_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      door_lamp_n   <= ALL_DARK;
      master_lamp_n <= 1'b1;
    end else begin
      door_lamp_n   <= door_next;
      master_lamp_n <= master_next;
    end
  end

  p_reset_dark_r1: assert property (@(posedge clk)
    rst |=> (&door_lamp_n && master_lamp_n));

  p_closed_dark_r2: assert property (@(posedge clk) disable iff (rst)
    (sel_warn == '0) |=> (&door_lamp_n && master_lamp_n));

  p_master_any_r3: assert property (@(posedge clk) disable iff (rst)
    (|sel_warn) |=> !master_lamp_n);

  p_door_map_r4: assert property (@(posedge clk) disable iff (rst)
    panel_en |=> (door_lamp_n == ~$past(sel_warn)));

  p_enable_gate_r5: assert property (@(posedge clk) disable iff (rst)
    !panel_en |=> &door_lamp_n);

  p_master_no_en_r6: assert property (@(posedge clk) disable iff (rst)
    (!panel_en && sel_any) |=> !master_lamp_n);
endmodule

// File: rtl/gear_door_annunciator.sv
module gear_door_annunciator #(
  parameter int unsigned N_DOORS = gda_pkg::DEFAULT_DOORS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_DOORS-1:0] doors_pri,
  input  logic [N_DOORS-1:0] doors_sec,
  input  logic               chan_sel,
  input  logic               panel_en,
  output logic [N_DOORS-1:0] door_lamp_n,
  output logic               master_lamp_n
);
  localparam int unsigned NCH = gda_pkg::CHANNELS;

  logic [N_DOORS-1:0] ch_doors [NCH];
  logic [N_DOORS-1:0] ch_warn  [NCH];
  logic               ch_any   [NCH];
  logic [N_DOORS-1:0] sel_warn;
  logic               sel_any;
  gda_pkg::chan_e     sel_e;

  assign ch_doors[0] = doors_pri;
  assign ch_doors[1] = doors_sec;
  assign sel_e       = gda_pkg::chan_e'(chan_sel);

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    gda_channel #(.N_DOORS(N_DOORS)) u_chan (
      .door_open (ch_doors[c]),
      .warn      (ch_warn[c]),
      .any_open  (ch_any[c])
    );
  end

  gda_select #(.N_DOORS(N_DOORS)) u_sel (
    .chan_sel (sel_e),
    .pri_warn (ch_warn[0]),
    .pri_any  (ch_any[0]),
    .sec_warn (ch_warn[1]),
    .sec_any  (ch_any[1]),
    .sel_warn (sel_warn),
    .sel_any  (sel_any)
  );

  gda_lamp_stage #(.N_DOORS(N_DOORS)) u_lamp (
    .clk           (clk),
    .rst           (rst),
    .panel_en      (panel_en),
    .sel_warn      (sel_warn),
    .sel_any       (sel_any),
    .door_lamp_n   (door_lamp_n),
    .master_lamp_n (master_lamp_n)
  );

  p_primary_pick_r7: assert property (@(posedge clk) disable iff (rst)
    (!chan_sel && panel_en) |=> (door_lamp_n == ~$past(doors_pri)));

  p_secondary_pick_r7: assert property (@(posedge clk) disable iff (rst)
    (chan_sel && panel_en) |=> (door_lamp_n == ~$past(doors_sec)));

  p_master_sec_r7: assert property (@(posedge clk) disable iff (rst)
    (chan_sel && (doors_sec == '0)) |=> master_lamp_n);
endmodule

// File: tb/sim_gear_door_annunciator.sv
module sim_gear_door_annunciator;
  logic       clk = 1'b0;
  logic       rst;
  logic [4:0] doors_pri, doors_sec;
  logic       chan_sel, panel_en;
  logic [4:0] door_lamp_n;
  logic       master_lamp_n;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  gear_door_annunciator u0 (
    .clk(clk), .rst(rst), .doors_pri(doors_pri), .doors_sec(doors_sec),
    .chan_sel(chan_sel), .panel_en(panel_en),
    .door_lamp_n(door_lamp_n), .master_lamp_n(master_lamp_n)
  );

  // {sel, en, pri[4:0], sec[4:0], expected door lamps[4:0], expected master}
  localparam logic [17:0] VEC [12] = '{
    18'b0_1_00000_00000_11111_1,
    18'b0_1_00001_00000_11110_0,
    18'b0_1_00101_00000_11010_0,
    18'b0_1_11111_00000_00000_0,
    18'b0_1_00000_11111_11111_1,
    18'b1_1_00000_10000_01111_0,
    18'b1_1_01010_00000_11111_1,
    18'b0_0_10101_00000_11111_0,
    18'b1_0_00000_00000_11111_1,
    18'b1_0_00000_00100_11111_0,
    18'b1_1_11111_01001_10110_0,
    18'b0_1_10000_01111_01111_0
  };

  task automatic check5(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic apply(input logic s, input logic e, input logic [4:0] p, input logic [4:0] q);
    @(negedge clk);
    chan_sel = s; panel_en = e; doors_pri = p; doors_sec = q;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(8 * 5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; chan_sel = 1'b0; panel_en = 1'b1;
    doors_pri = 5'b11111; doors_sec = 5'b11111;
    @(posedge clk); #2;
    check5("R1 reset door lamps with doors open", door_lamp_n, 5'b11111);
    check1("R1 reset master with doors open", master_lamp_n, 1'b1);
    @(negedge clk); rst = 1'b0;

    // table walk: door lamps cover R4 R5 R7, master covers R3 R6 R7
    for (int i = 0; i < 12; i++) begin
      apply(VEC[i][17], VEC[i][16], VEC[i][15:11], VEC[i][10:6]);
      check5($sformatf("R4 R5 R7 vector %0d door lamps", i), door_lamp_n, VEC[i][5:1]);
      check1($sformatf("R3 R6 R7 vector %0d master", i), master_lamp_n, VEC[i][0]);
    end

    // R2: all closed on the selected channel, the other channel full open
    apply(1'b1, 1'b1, 5'b11111, 5'b00000);
    check5("R2 closed door lamps", door_lamp_n, 5'b11111);
    check1("R2 closed master", master_lamp_n, 1'b1);

    // R8: change between edges, output holds until next rising edge
    @(negedge clk);
    chan_sel = 1'b0; doors_pri = 5'b00010;
    #1;
    check5("R8 held door lamps before edge", door_lamp_n, 5'b11111);
    check1("R8 held master before edge", master_lamp_n, 1'b1);
    @(posedge clk); #2;
    check5("R8 door lamps after edge", door_lamp_n, 5'b11101);
    check1("R8 master after edge", master_lamp_n, 1'b0);

    // R1: reset asserted mid-run clears lamps
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #2;
    check5("R1 mid-run reset door lamps", door_lamp_n, 5'b11111);
    check1("R1 mid-run reset master", master_lamp_n, 1'b1);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #2;
    check5("R4 after reset release", door_lamp_n, 5'b11101);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule